// File: doc/BRIEF.md
# Correctable-Error Line Retirement Tracker

This block watches the stream of single-bit corrected ECC events reported by a cache and decides when a cache line should be retired. Each report carries the set and way of the corrected line. The first report for a location only logs that location in a small history queue, and the line stays valid and untouched. A second report for a logged location treats the fault as likely permanent and marks the line as disabled. Tracking runs every cycle that reset is released, so it covers self-test and normal operation alike.

Disabled lines are held in a per-set bitmap that the allocation logic reads through a combinational lookup port. The port returns the disabled flag for one set/way and the full disabled-way mask of that set. Retirement is bounded by a global limit and by a per-set limit. A request beyond either limit is refused and recorded in a sticky flag. A full history queue refuses new first-time locations in the same way. Nothing is released before the next reset.

Top module: `line_retire_tracker`

## Requirements
- R1: A corrected-error report for a location that is neither logged nor disabled adds it to the history queue and disables nothing: `disabled_count` and the lookup result stay unchanged.
- R2: A report for a location already in the history queue disables that line when both limits allow it. From the cycle after the report, the lookup shows it disabled and `disabled_count` is one higher.
- R3: At most MAX_DIS (default 32) lines are disabled in total. A disable refused by this limit leaves the count unchanged and sets `cap_overflow`, which stays high until reset.
- R4: At most MAX_PER_SET (default 2) ways of one set are disabled. A disable refused by this limit leaves the set's mask unchanged and sets `cap_overflow`.
- R5: A disabled line stays disabled until reset. Reports to a disabled line have no effect. Reset clears every disabled line.
- R6: `hist_full` is high while all HIST_DEPTH (default 8) queue entries are occupied. A first-time report arriving then is dropped, and `hist_overflow` is set and stays high until reset. Entries already logged are kept and can still be promoted.
- R7: A location promoted to disabled is removed from the history queue, which frees its entry.
- R8: The lookup port is combinational. `lk_disabled` gives the state of (`lk_set`, `lk_way`), and bit w of `lk_way_mask` is 1 exactly when way w of `lk_set` is disabled.
- R9: After reset, nothing is disabled, the count is 0 and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Corrected-error report strobe |
| err_set | input | SET_W | Set of the reported line |
| err_way | input | WAY_W | Way of the reported line |
| lk_set | input | SET_W | Lookup set |
| lk_way | input | WAY_W | Lookup way |
| lk_disabled | output | 1 | Looked-up line is disabled |
| lk_way_mask | output | WAYS | Disabled ways of the looked-up set |
| hist_full | output | 1 | History queue has no free entry |
| hist_overflow | output | 1 | Sticky: a first-time report was dropped |
| cap_overflow | output | 1 | Sticky: a disable was refused by a limit |
| disabled_count | output | CNT_W | Number of disabled lines |

## Verification
A report is sampled on one rising edge. Its effect on the count, on the sticky flags, on `hist_full` and on the lookup is therefore due one edge later. The bench drives every report on a falling edge and removes it on the next falling edge, then compares outputs at that second falling edge, which is half a cycle after the edge that updated them. The lookup port carries no register, so lookup checks change `lk_set`/`lk_way` between edges and compare after a short settle delay, with no clock edge in between.

// File: rtl/line_retire_pkg.sv
package line_retire_pkg;

   // Outcome of one corrected-error report
   typedef enum logic [2:0] {
      ACT_NONE    = 3'd0,
      ACT_LOG     = 3'd1,
      ACT_DROP    = 3'd2,
      ACT_DISABLE = 3'd3,
      ACT_REFUSE  = 3'd4,
      ACT_IGNORE  = 3'd5
   } err_act_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lrt_hist_queue.sv
module lrt_hist_queue #(
   parameter int DEPTH = 8,
   parameter int SET_W = 6,
   parameter int WAY_W = 4,
   localparam int IDX_W = line_retire_pkg::idx_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] q_set,
   input  logic [WAY_W-1:0] q_way,
   input  logic             ins_en,
   input  logic             del_en,
   input  logic [IDX_W-1:0] del_idx,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic             full
);

   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] match;
   logic [SET_W-1:0] set_q [DEPTH];
   logic [WAY_W-1:0] way_q [DEPTH];
   logic [IDX_W-1:0] free_idx;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[i] <= 1'b0;
               set_q[i] <= '0;
               way_q[i] <= '0;
            end else if (ins_en && (free_idx == IDX_W'(i))) begin
               vld_q[i] <= 1'b1;
               set_q[i] <= q_set;
               way_q[i] <= q_way;
            end else if (del_en && (del_idx == IDX_W'(i))) begin
               vld_q[i] <= 1'b0;
            end
         end
         assign match[i] = vld_q[i] && (set_q[i] == q_set) && (way_q[i] == q_way);
      end
   endgenerate

   always_comb begin
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) free_idx = IDX_W'(i);
      end
   end

   assign hit  = |match;
   assign full = &vld_q;

   initial begin : prm_chk
      assert (DEPTH >= 1) else $error("DEPTH must be at least 1");
   end

   // R6
   ins_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !full);

   // R7
   one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ins_en, del_en}));

   // R7
   del_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (del_en && full) |=> !full);

endmodule

// File: rtl/lrt_dis_table.sv
module lrt_dis_table #(
   parameter int SETS    = 64,
   parameter int WAYS    = 16,
   parameter int MAX_DIS = 32,
   localparam int SET_W  = line_retire_pkg::idx_width(SETS),
   localparam int WAY_W  = line_retire_pkg::idx_width(WAYS),
   localparam int CNT_W  = $clog2(MAX_DIS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark_en,
   input  logic [SET_W-1:0] mark_set,
   input  logic [WAY_W-1:0] mark_way,
   input  logic [SET_W-1:0] rd_a_set,
   output logic [WAYS-1:0]  rd_a_row,
   input  logic [SET_W-1:0] rd_b_set,
   output logic [WAYS-1:0]  rd_b_row,
   output logic [CNT_W-1:0] count
);

   logic [WAYS-1:0] row_q [SETS];
   logic [CNT_W-1:0] cnt_q;

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_row
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               row_q[s] <= '0;
            end else if (mark_en && (mark_set == SET_W'(s))) begin
               row_q[s][mark_way] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (mark_en) cnt_q <= cnt_q + 1'b1;
   end

   assign rd_a_row = row_q[rd_a_set];
   assign rd_b_row = row_q[rd_b_set];
   assign count    = cnt_q;

   initial begin : prm_chk
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0) else $error("SETS must be a power of two");
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0) else $error("WAYS must be a power of two");
      assert (MAX_DIS >= 1) else $error("MAX_DIS must be at least 1");
   end

   // R3
   glob_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= MAX_DIS);

   // R5
   count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count >= $past(count));

   // R5
   row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(rd_a_set) |-> ((rd_a_row & $past(rd_a_row)) == $past(rd_a_row)));

endmodule

// File: rtl/line_retire_tracker.sv
module line_retire_tracker
   import line_retire_pkg::*;
#(
   parameter int SETS        = 64,
   parameter int WAYS        = 16,
   parameter int HIST_DEPTH  = 8,
   parameter int MAX_DIS     = 32,
   parameter int MAX_PER_SET = 2,
   localparam int SET_W = idx_width(SETS),
   localparam int WAY_W = idx_width(WAYS),
   localparam int CNT_W = $clog2(MAX_DIS + 1),
   localparam int IDX_W = idx_width(HIST_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_valid,
   input  logic [SET_W-1:0] err_set,
   input  logic [WAY_W-1:0] err_way,
   input  logic [SET_W-1:0] lk_set,
   input  logic [WAY_W-1:0] lk_way,
   output logic             lk_disabled,
   output logic [WAYS-1:0]  lk_way_mask,
   output logic             hist_full,
   output logic             hist_overflow,
   output logic             cap_overflow,
   output logic [CNT_W-1:0] disabled_count
);

   err_act_t         act;
   logic [WAYS-1:0]  err_row;
   logic             err_dis;
   logic             h_hit;
   logic [IDX_W-1:0] h_idx;
   logic             limits_ok;
   logic             hov_q;
   logic             cov_q;

   assign err_dis   = err_row[err_way];
   assign limits_ok = (int'(disabled_count) < MAX_DIS) && ($countones(err_row) < MAX_PER_SET);

   always_comb begin
      act = ACT_NONE;
      if (err_valid) begin
         if (err_dis)        act = ACT_IGNORE;
         else if (h_hit)     act = limits_ok ? ACT_DISABLE : ACT_REFUSE;
         else if (hist_full) act = ACT_DROP;
         else                act = ACT_LOG;
      end
   end

   lrt_hist_queue #(
      .DEPTH (HIST_DEPTH),
      .SET_W (SET_W),
      .WAY_W (WAY_W)
   ) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .q_set   (err_set),
      .q_way   (err_way),
      .ins_en  (act == ACT_LOG),
      .del_en  (act == ACT_DISABLE),
      .del_idx (h_idx),
      .hit     (h_hit),
      .hit_idx (h_idx),
      .full    (hist_full)
   );

   lrt_dis_table #(
      .SETS    (SETS),
      .WAYS    (WAYS),
      .MAX_DIS (MAX_DIS)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .mark_en  (act == ACT_DISABLE),
      .mark_set (err_set),
      .mark_way (err_way),
      .rd_a_set (lk_set),
      .rd_a_row (lk_way_mask),
      .rd_b_set (err_set),
      .rd_b_row (err_row),
      .count    (disabled_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hov_q <= 1'b0;
         cov_q <= 1'b0;
      end else begin
         if (act == ACT_DROP)   hov_q <= 1'b1;
         if (act == ACT_REFUSE) cov_q <= 1'b1;
      end
   end

   assign hist_overflow = hov_q;
   assign cap_overflow  = cov_q;
   assign lk_disabled   = lk_way_mask[lk_way];

   initial begin : prm_chk
      assert (MAX_PER_SET >= 1 && MAX_PER_SET <= WAYS) else $error("MAX_PER_SET out of range");
      assert (MAX_DIS <= SETS * MAX_PER_SET) else $error("MAX_DIS unreachable");
   end

   // R1
   log_no_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOG) |=> (disabled_count == $past(disabled_count)));

   // R2
   promote_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_DISABLE) |=> (disabled_count == $past(disabled_count) + 1'b1));

   // R4
   set_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lk_way_mask) <= MAX_PER_SET);

   // R3
   cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cap_overflow) |-> cap_overflow);

   // R6
   drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_DROP) |=> hist_overflow);

endmodule

// File: tb/line_retire_tracker_bench.sv
module line_retire_tracker_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_valid = 1'b0;
   logic [5:0]  err_set = '0;
   logic [3:0]  err_way = '0;
   logic [5:0]  lk_set = '0;
   logic [3:0]  lk_way = '0;
   logic        lk_disabled;
   logic [15:0] lk_way_mask;
   logic        hist_full;
   logic        hist_overflow;
   logic        cap_overflow;
   logic [5:0]  disabled_count;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   line_retire_tracker u_line_retire_tracker (
      .clk            (clk),
      .rst_n          (rst_n),
      .err_valid      (err_valid),
      .err_set        (err_set),
      .err_way        (err_way),
      .lk_set         (lk_set),
      .lk_way         (lk_way),
      .lk_disabled    (lk_disabled),
      .lk_way_mask    (lk_way_mask),
      .hist_full      (hist_full),
      .hist_overflow  (hist_overflow),
      .cap_overflow   (cap_overflow),
      .disabled_count (disabled_count)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      err_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic report(input int s, input int w);
      err_valid = 1'b1;
      err_set = 6'(s);
      err_way = 4'(w);
      @(negedge clk);
      err_valid = 1'b0;
   endtask

   task automatic look(input int s, input int w);
      lk_set = 6'(s);
      lk_way = 4'(w);
      #1;
   endtask

   task automatic t_reset_state();
      do_reset();
      look(5, 3);
      chk("R9", "count", int'(disabled_count), 0);
      chk("R9", "flags", int'({hist_full, hist_overflow, cap_overflow}), 0);
      chk("R9", "mask", int'(lk_way_mask), 0);
   endtask

   task automatic t_first_then_second();
      report(5, 3);
      look(5, 3);
      chk("R1", "disabled after first", int'(lk_disabled), 0);
      chk("R1", "count after first", int'(disabled_count), 0);
      report(5, 3);
      look(5, 3);
      chk("R2", "disabled after second", int'(lk_disabled), 1);
      chk("R2", "count after second", int'(disabled_count), 1);
      chk("R8", "mask set 5", int'(lk_way_mask), 16'h0008);
      look(5, 2);
      chk("R8", "neighbour way", int'(lk_disabled), 0);
      look(4, 3);
      chk("R8", "neighbour set mask", int'(lk_way_mask), 0);
      report(5, 3);
      report(5, 3);
      look(5, 3);
      chk("R5", "count after repeats", int'(disabled_count), 1);
      chk("R5", "still disabled", int'(lk_disabled), 1);
   endtask

   task automatic t_set_limit();
      for (int w = 1; w <= 3; w++) begin
         report(7, w);
         report(7, w);
      end
      look(7, 3);
      chk("R4", "set 7 mask", int'(lk_way_mask), 16'h0006);
      chk("R4", "refused way", int'(lk_disabled), 0);
      chk("R4", "cap flag", int'(cap_overflow), 1);
      chk("R4", "count", int'(disabled_count), 3);
      repeat (5) @(negedge clk);
      chk("R3", "cap flag sticky", int'(cap_overflow), 1);
   endtask

   task automatic t_hist_full();
      do_reset();
      for (int i = 0; i < 8; i++) report(10 + i, 4);
      chk("R6", "full after 8", int'(hist_full), 1);
      chk("R6", "no drop yet", int'(hist_overflow), 0);
      report(30, 9);
      chk("R6", "drop flag", int'(hist_overflow), 1);
      report(30, 9);
      look(30, 9);
      chk("R6", "dropped not disabled", int'(lk_disabled), 0);
      chk("R6", "count", int'(disabled_count), 0);
      report(13, 4);
      look(13, 4);
      chk("R6", "kept entry promotes", int'(lk_disabled), 1);
      chk("R7", "entry freed", int'(hist_full), 0);
      report(30, 9);
      chk("R7", "refilled", int'(hist_full), 1);
      report(30, 9);
      look(30, 9);
      chk("R7", "new entry promotes", int'(lk_disabled), 1);
   endtask

   task automatic t_global_limit();
      do_reset();
      for (int s = 0; s < 16; s++) begin
         for (int w = 0; w < 2; w++) begin
            report(s, w);
            report(s, w);
         end
      end
      chk("R3", "count at limit", int'(disabled_count), 32);
      chk("R3", "no flag at limit", int'(cap_overflow), 0);
      report(20, 0);
      report(20, 0);
      look(20, 0);
      chk("R3", "extra refused", int'(lk_disabled), 0);
      chk("R3", "count held", int'(disabled_count), 32);
      chk("R3", "flag", int'(cap_overflow), 1);
      look(15, 1);
      chk("R5", "last line kept", int'(lk_disabled), 1);
      do_reset();
      look(15, 1);
      chk("R5", "cleared by reset", int'(lk_disabled), 0);
      chk("R5", "count cleared", int'(disabled_count), 0);
      chk("R9", "flags cleared", int'({hist_full, hist_overflow, cap_overflow}), 0);
   endtask

   initial begin
      t_reset_state();
      t_first_then_second();
      t_set_limit();
      t_hist_full();
      t_global_limit();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule